// File: doc/BRIEF.md
# Three-Wire Serial Configuration Register Bank

This block holds eight 8-bit configuration registers that are written over a three-wire serial port made of a load strobe, a serial clock and a serial data line. All three are sampled in the system clock domain through synchronizers. The port only listens while the mode-select input is high. While mode-select is high, the enable for the block's parallel output bus is withdrawn so that the shared pins can carry the serial signals.

A frame opens when the strobe falls. Each rising edge of the serial clock shifts in one bit, most significant bit first. The first three bits give the register address and the next eight give the data. The word commits when the strobe rises, and only if the bit count has reached eleven. Bits that arrive after the eleventh are dropped.

The register at address 6 carries two command bits. Bit 6 restores the whole bank to its power-up values. Bit 7 flags power-down, which leaves the stored settings in place but marks the signal-configuration field as stale until address 6 is written again.

Top module: `serial_cfg_bank`

## Requirements
- R1: `bus_oe` is the inverse of `sel_mode`. While `sel_mode` is low, strobe, clock and data activity writes no register.
- R2: A frame of eleven bits, sent MSB first, writes data bits [7:0] into the register named by address bits [10:8] when the strobe rises. Register k appears on `regs_o[8k+7:8k]`.
- R3: If fewer than eleven serial-clock rising edges arrive while the strobe is low, the strobe's rising edge writes no register.
- R4: Serial-clock edges after the eleventh in one strobe-low window are ignored. Only the first eleven bits are used.
- R5: After `rst_n` is released, addresses 1, 3 and 5 hold 0x40 and every other address holds 0x00.
- R6: The gain registers at addresses 0, 2 and 4 store bits 7:2 of the written data. Their bits 1:0 always read 0.
- R7: Writing address 6 with bit 6 set returns all eight registers to their R5 values, including address 6, which ends at 0x00. It also sets `cfg_valid` to 1.
- R8: Writing address 6 with bit 7 set (and bit 6 clear) stores the value, leaves every other register unchanged and drives `cfg_valid` to 0. A later write to address 6 with bit 7 clear returns `cfg_valid` to 1. `cfg_valid` is 1 after reset.
- R9: A falling strobe discards the bits of any earlier frame, so a frame that follows an aborted partial frame writes exactly its own eleven bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_mode | input | 1 | High enables the serial port and withdraws the output bus enable |
| ld_n | input | 1 | Load strobe: low opens a frame, rising commits it |
| sclk | input | 1 | Serial clock; data sampled on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| bus_oe | output | 1 | Parallel output bus enable |
| regs_o | output | 64 | All eight registers, register k at bits 8k+7:8k |
| cfg_valid | output | 1 | Signal-configuration field of address 6 is current |

## Verification
The bench targets the bit-count edges: frames of zero, ten, eleven and fourteen clocks. A design that commits short frames would corrupt a register on an aborted write. A design that keeps shifting past eleven would store the trailing bits in place of the real address and data. A partial frame followed by a full frame shows whether the counter really restarts on the falling strobe. If it did not, the leftover count would freeze the shift register early and the wrong word would land.

The command bits of address 6 are exercised both alone and together. A soft reset issued while power-down is set must bring back every default and `cfg_valid`. A power-down write must leave the other seven registers untouched. Frames sent with `sel_mode` low must change nothing. Writes to the gain addresses use data with the low bits set, to show that those bits are dropped.

// File: rtl/serial_cfg_bank.sv
module serial_cfg_bank #(
  parameter int ADDR_W   = 3,
  parameter int DATA_W   = 8,
  parameter int SYNC_N   = 2,
  parameter int MODE_A   = 6,
  parameter int SRST_BIT = 6,
  parameter int PD_BIT   = 7,
  parameter int GAIN_IGN = 2,
  parameter logic [DATA_W-1:0] OFFS_RST = 8'h40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sel_mode,
  input  logic                         ld_n,
  input  logic                         sclk,
  input  logic                         sdata,
  output logic                         bus_oe,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  output logic                         cfg_valid
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int FRAME = ADDR_W + DATA_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [CW-1:0] FULL = CW'(FRAME);

  function automatic logic [DATA_W-1:0] dflt(input int a);
    return (a < MODE_A && a % 2 == 1) ? OFFS_RST : '0;
  endfunction

  function automatic logic [DATA_W-1:0] keep_mask(input int a);
    logic [DATA_W-1:0] m;
    m = '1;
    if (a < MODE_A && a % 2 == 0) m[GAIN_IGN-1:0] = '0;
    return m;
  endfunction

  logic [SYNC_N-1:0] ld_sy, ck_sy, dt_sy;
  logic ld_q, ck_q;
  logic [CW-1:0] cnt;
  logic [FRAME-1:0] shreg;
  logic [DATA_W-1:0] bank [NREG];

  wire ld_s = ld_sy[SYNC_N-1];
  wire ck_s = ck_sy[SYNC_N-1];
  wire dt_s = dt_sy[SYNC_N-1];

  wire ld_fall = sel_mode & ~ld_s & ld_q;
  wire ld_rise = sel_mode & ld_s & ~ld_q;
  wire ck_rise = sel_mode & ~ld_s & ck_s & ~ck_q;
  wire commit  = ld_rise && cnt == FULL;

  wire [ADDR_W-1:0] waddr = shreg[FRAME-1:DATA_W];
  wire [DATA_W-1:0] wdata = shreg[DATA_W-1:0];
  wire to_mode = commit && waddr == ADDR_W'(MODE_A);
  wire soft_rst = to_mode && wdata[SRST_BIT];

  assign bus_oe = ~sel_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ld_sy <= '1;
      ck_sy <= '0;
      dt_sy <= '0;
      ld_q  <= 1'b1;
      ck_q  <= 1'b0;
    end else begin
      ld_sy <= {ld_sy[SYNC_N-2:0], ld_n};
      ck_sy <= {ck_sy[SYNC_N-2:0], sclk};
      dt_sy <= {dt_sy[SYNC_N-2:0], sdata};
      ld_q  <= ld_s;
      ck_q  <= ck_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (!sel_mode || ld_fall) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (ck_rise && cnt != FULL) begin
      cnt   <= cnt + 1'b1;
      shreg <= {shreg[FRAME-2:0], dt_s};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) bank[i] <= dflt(i);
    end else if (soft_rst) begin
      for (int i = 0; i < NREG; i++) bank[i] <= dflt(i);
    end else if (commit) begin
      for (int i = 0; i < NREG; i++)
        if (waddr == ADDR_W'(i)) bank[i] <= wdata & keep_mask(i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cfg_valid <= 1'b1;
    else if (soft_rst) cfg_valid <= 1'b1;
    else if (to_mode)  cfg_valid <= ~wdata[PD_BIT];
  end

  for (genvar g = 0; g < NREG; g++) begin : g_out
    assign regs_o[g*DATA_W +: DATA_W] = bank[g];
  end
endmodule

// File: rtl/serial_cfg_bank_chk.sv
module serial_cfg_bank_chk #(
  parameter int NREG     = 8,
  parameter int DATA_W   = 8,
  parameter int CW       = 4,
  parameter int FRAME    = 11,
  parameter int MODE_A   = 6,
  parameter int SRST_BIT = 6
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   sel_mode,
  input logic                   bus_oe,
  input logic [NREG*DATA_W-1:0] regs_o,
  input logic [CW-1:0]          cnt,
  input logic                   ld_rise
);
  assert_oe_off_R1: assert property (@(posedge clk) disable iff (!rst_n)
    sel_mode |-> !bus_oe);

  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sel_mode) |-> $stable(regs_o));

  assert_short_nowrite_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_rise && cnt != CW'(FRAME)) |=> $stable(regs_o));

  assert_cnt_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(FRAME));

  assert_gain_lsb_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (regs_o[0*DATA_W +: 2] | regs_o[2*DATA_W +: 2] | regs_o[4*DATA_W +: 2]) == 2'b00);

  assert_srst_selfclear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    regs_o[MODE_A*DATA_W + SRST_BIT] == 1'b0);
endmodule

bind serial_cfg_bank serial_cfg_bank_chk #(
  .NREG(NREG), .DATA_W(DATA_W), .CW(CW), .FRAME(FRAME),
  .MODE_A(MODE_A), .SRST_BIT(SRST_BIT)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .bus_oe(bus_oe),
  .regs_o(regs_o), .cnt(cnt), .ld_rise(ld_rise)
);

// File: tb/serial_cfg_bank_bench.sv
module serial_cfg_bank_bench;
  logic clk = 0, rst_n = 0, sel_mode = 0, ld_n = 1, sclk = 0, sdata = 0;
  logic bus_oe, cfg_valid;
  logic [63:0] regs_o;
  int tests = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp [8];

  always #10 clk = ~clk;

  serial_cfg_bank u_serial_cfg_bank (
    .clk(clk), .rst_n(rst_n), .sel_mode(sel_mode), .ld_n(ld_n),
    .sclk(sclk), .sdata(sdata), .bus_oe(bus_oe), .regs_o(regs_o),
    .cfg_valid(cfg_valid));

  task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
    tests++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  task automatic defaults();
    for (int i = 0; i < 8; i++) exp[i] = (i < 6 && i % 2 == 1) ? 8'h40 : 8'h00;
  endtask

  task automatic check_bank(string req);
    for (int i = 0; i < 8; i++) chk(req, regs_o[i*8 +: 8], exp[i]);
  endtask

  task automatic wait_clk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send(int nbits, logic [2:0] a, logic [7:0] d, logic extra);
    logic [10:0] w;
    w = {a, d};
    ld_n = 0;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      sdata = (i < 11) ? w[10-i] : extra;
      wait_clk(2);
      sclk = 1;
      wait_clk(4);
      sclk = 0;
      wait_clk(2);
    end
    ld_n = 1;
    wait_clk(6);
  endtask

  task automatic t_reset();
    defaults();
    check_bank("R5");
    chk("R1", bus_oe, 1);
    chk("R8", cfg_valid, 1);
    sel_mode = 1;
    wait_clk(1);
    chk("R1", bus_oe, 0);
  endtask

  task automatic t_each_addr();
    logic [7:0] d;
    for (int a = 0; a < 8; a++) begin
      d = (a == 6) ? 8'h2D : 8'h13 + 8'(a * 37);
      d[1:0] = 2'b11;
      if (a == 6) d = 8'h2D;
      send(11, 3'(a), d, 0);
      exp[a] = (a < 6 && a % 2 == 0) ? {d[7:2], 2'b00} : d;
      check_bank((a < 6 && a % 2 == 0) ? "R6" : "R2");
    end
    chk("R8", cfg_valid, 1);
  endtask

  task automatic t_short();
    send(10, 3'd1, 8'hFF, 0);
    check_bank("R3");
    send(0, 3'd1, 8'hFF, 0);
    check_bank("R3");
  endtask

  task automatic t_long();
    send(14, 3'd3, 8'h12, 1);
    exp[3] = 8'h12;
    check_bank("R4");
  endtask

  task automatic t_sel_low();
    sel_mode = 0;
    wait_clk(1);
    chk("R1", bus_oe, 1);
    send(11, 3'd7, 8'h00, 0);
    check_bank("R1");
    sel_mode = 1;
    wait_clk(2);
  endtask

  task automatic t_abort();
    send(6, 3'd7, 8'hFF, 0);
    check_bank("R9");
    send(11, 3'd5, 8'h9C, 0);
    exp[5] = 8'h9C;
    check_bank("R9");
  endtask

  task automatic t_power_down();
    send(11, 3'd6, 8'h81, 0);
    exp[6] = 8'h81;
    check_bank("R8");
    chk("R8", cfg_valid, 0);
    send(11, 3'd6, 8'h02, 0);
    exp[6] = 8'h02;
    check_bank("R8");
    chk("R8", cfg_valid, 1);
  endtask

  task automatic t_soft_reset();
    send(11, 3'd6, 8'h80, 0);
    chk("R8", cfg_valid, 0);
    send(11, 3'd6, 8'hC3, 0);
    defaults();
    check_bank("R7");
    chk("R7", cfg_valid, 1);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1;
    wait_clk(2);
    t_reset();
    t_each_addr();
    t_short();
    t_long();
    t_sel_low();
    t_abort();
    t_power_down();
    t_soft_reset();
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule